// File: doc/BRIEF.md
# Two-Master Shared Bus Ownership Arbiter

This block decides which of two bus masters drives a single shared processor bus. No separate bus controller is involved. At any moment one master is the owner, the most recently used master, and only the owner may put cycles on the bus. The other master is the waiter, the least recently used master, and it asks for the bus by raising its request. A strap input picks which master is primary. After reset the primary master is the owner and the secondary master waits.

The owner gives up the bus once it has no outstanding transactions. It also gives up the bus early when the bus signals that a new cycle can be pipelined onto the one in flight. In either case the waiter takes ownership on the next clock, so a handoff adds no idle clock.

While a handoff is pending, the owner may start one more cycle. After that its start permission is withheld until the swap happens or the waiter withdraws. Ownership alternates strictly, so two masters that both keep requesting take turns. When the second socket is empty, the primary keeps the bus permanently.

Top module: `dmba_top`

## Requirements
- R1: A reset loads ownership from the strap. With `prim_sel_i`=0, master 0 is primary. With `prim_sel_i`=1, master 1 is primary. The primary is the owner after reset (`owner_o` equals its index and only its bit of `gnt_o` is set).
- R2: In every cycle after reset exactly one bit of `gnt_o` is high, and it is bit `owner_o`. The waiter's bit of `ads_ok_o` is always 0. Bit i of every two-bit port belongs to master i.
- R3: If the peer is present, the waiter's request is high and the owner's `pend_i` bit is low, then ownership passes to the waiter at the next clock edge.
- R4: If the waiter requests, the owner's `pend_i` bit is high and `pipe_rdy_i` is high, then ownership passes to the waiter at the next clock edge.
- R5: If the waiter requests, the owner's `pend_i` bit is high and `pipe_rdy_i` is low, then ownership does not change.
- R6: While a handoff is pending, the owner's `ads_ok_o` bit stays high until the owner starts one cycle (its `ads_i` bit is high while permitted). The bit is then low until the swap or until the request is withdrawn.
- R7: When both masters request and no transaction is pending, ownership alternates at every clock edge.
- R8: If the waiter drops its request before the swap, the owner keeps the bus and its one-extra-cycle allowance is restored.
- R9: When `peer_present_i` is low, the primary becomes the owner at the next edge and keeps the bus whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prim_sel_i | input | 1 | Strap: index of the primary master |
| peer_present_i | input | 1 | Second master is installed |
| req_i | input | 2 | Per-master bus request |
| pend_i | input | 2 | Per-master outstanding-transaction flag |
| pipe_rdy_i | input | 1 | Bus accepts a pipelined next cycle now |
| ads_i | input | 2 | Per-master cycle start strobe |
| gnt_o | output | 2 | Per-master bus grant |
| owner_o | output | 1 | Index of the current owner |
| ads_ok_o | output | 2 | Per-master permission to start a cycle |

## Verification
The hardest case to reach is the spent allowance. The owner's start permission is only removed after the waiter has requested while the owner is busy, the pipeline is not ready, and the owner has already used its one extra start. The vector table reaches this by holding the owner's pending flag high across several vectors with `pipe_rdy_i` low, strobing `ads_i` once, and then checking that the permission stays low. A later group of vectors withdraws the request in the spent state to show that the allowance comes back.

// File: rtl/dmba_pkg.sv
package dmba_pkg;
    localparam int unsigned NUM_MST = 2;
    localparam int unsigned IDX_W   = $clog2(NUM_MST);

    typedef logic [IDX_W-1:0]   mst_idx_t;
    typedef logic [NUM_MST-1:0] mst_vec_t;

    typedef struct packed {
        mst_idx_t owner;   // most recently used master
        logic     spent;   // extra cycle used during pending handoff
    } arb_state_t;
endpackage

// File: rtl/dmba_decide.sv
module dmba_decide
    import dmba_pkg::*;
(
    input  mst_idx_t owner_q,
    input  logic     present,
    input  mst_vec_t req,
    input  mst_vec_t pend,
    input  logic     pipe_rdy,
    output mst_idx_t waiter,
    output logic     want,
    output logic     swap
);
    always_comb begin
        waiter = ~owner_q;
        want   = present & req[waiter];
        // a handoff needs a drained owner or a pipelinable slot
        swap   = want & (~pend[owner_q] | pipe_rdy);
    end
endmodule

// File: rtl/dmba_state.sv
module dmba_state
    import dmba_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mst_idx_t prim,
    input  logic     present,
    input  logic     want,
    input  logic     swap,
    input  mst_idx_t waiter,
    input  logic     owner_start,
    output arb_state_t st_q
);
    arb_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (!present) begin
            st_d.owner = prim;
            st_d.spent = 1'b0;
        end else if (swap) begin
            st_d.owner = waiter;
            st_d.spent = 1'b0;
        end else if (!want) begin
            st_d.spent = 1'b0;
        end else if (owner_start) begin
            st_d.spent = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= prim;
            st_q.spent <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dmba_out.sv
module dmba_out
    import dmba_pkg::*;
(
    input  arb_state_t st_q,
    input  logic       want,
    output mst_vec_t   gnt,
    output mst_vec_t   ads_ok
);
    for (genvar i = 0; i < NUM_MST; i++) begin : g_mst
        always_comb begin
            gnt[i]    = (st_q.owner == mst_idx_t'(i));
            ads_ok[i] = gnt[i] & ~(want & st_q.spent);
        end
    end
endmodule

// File: rtl/dmba_top.sv
module dmba_top
    import dmba_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prim_sel_i,
    input  logic       peer_present_i,
    input  logic [1:0] req_i,
    input  logic [1:0] pend_i,
    input  logic       pipe_rdy_i,
    input  logic [1:0] ads_i,
    output logic [1:0] gnt_o,
    output logic       owner_o,
    output logic [1:0] ads_ok_o
);
    arb_state_t st_q;
    mst_idx_t   waiter;
    logic       want;
    logic       swap;
    logic       owner_start;

    dmba_decide i_decide (
        .owner_q  (st_q.owner),
        .present  (peer_present_i),
        .req      (req_i),
        .pend     (pend_i),
        .pipe_rdy (pipe_rdy_i),
        .waiter   (waiter),
        .want     (want),
        .swap     (swap)
    );

    assign owner_start = ads_i[st_q.owner] & ads_ok_o[st_q.owner];

    dmba_state i_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .prim        (prim_sel_i),
        .present     (peer_present_i),
        .want        (want),
        .swap        (swap),
        .waiter      (waiter),
        .owner_start (owner_start),
        .st_q        (st_q)
    );

    dmba_out i_out (
        .st_q   (st_q),
        .want   (want),
        .gnt    (gnt_o),
        .ads_ok (ads_ok_o)
    );

    assign owner_o = st_q.owner;
endmodule

// File: rtl/dmba_chk.sv
module dmba_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prim_sel_i,
    input logic       peer_present_i,
    input logic [1:0] req_i,
    input logic [1:0] pend_i,
    input logic       pipe_rdy_i,
    input logic [1:0] gnt_o,
    input logic       owner_o,
    input logic [1:0] ads_ok_o
);
    logic       seen_q;
    logic       own_p, pres_p, prim_p, pipe_p;
    logic [1:0] req_p, pend_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            own_p  <= 1'b0;
            pres_p <= 1'b0;
            prim_p <= 1'b0;
            pipe_p <= 1'b0;
            req_p  <= '0;
            pend_p <= '0;
        end else begin
            seen_q <= 1'b1;
            own_p  <= owner_o;
            pres_p <= peer_present_i;
            prim_p <= prim_sel_i;
            pipe_p <= pipe_rdy_i;
            req_p  <= req_i;
            pend_p <= pend_i;
        end
    end

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_o) == 1 && gnt_o[owner_o]);

    // R2
    waiter_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ads_ok_o[~owner_o] == 1'b0);

    // R3 R4 R5
    swap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pres_p && owner_o != own_p) |->
            (req_p[owner_o] && (!pend_p[own_p] || pipe_p)));

    // R8
    no_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pres_p && !req_p[~own_p]) |-> owner_o == own_p);

    // R9
    absent_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !pres_p) |-> owner_o == prim_p);
endmodule

bind dmba_top dmba_chk i_dmba_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .prim_sel_i     (prim_sel_i),
    .peer_present_i (peer_present_i),
    .req_i          (req_i),
    .pend_i         (pend_i),
    .pipe_rdy_i     (pipe_rdy_i),
    .gnt_o          (gnt_o),
    .owner_o        (owner_o),
    .ads_ok_o       (ads_ok_o)
);

// File: tb/test_dmba_top.sv
module test_dmba_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prim_sel_i = 1'b0;
    logic       peer_present_i = 1'b1;
    logic [1:0] req_i = '0;
    logic [1:0] pend_i = '0;
    logic       pipe_rdy_i = 1'b0;
    logic [1:0] ads_i = '0;
    logic [1:0] gnt_o;
    logic       owner_o;
    logic [1:0] ads_ok_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmba_top i_dmba_top (
        .clk(clk), .rst_n(rst_n), .prim_sel_i(prim_sel_i),
        .peer_present_i(peer_present_i), .req_i(req_i), .pend_i(pend_i),
        .pipe_rdy_i(pipe_rdy_i), .ads_i(ads_i), .gnt_o(gnt_o),
        .owner_o(owner_o), .ads_ok_o(ads_ok_o)
    );

    // {present, prim, req[1:0], pend[1:0], pipe, ads[1:0], exp_ok[1:0], exp_owner}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        13'b1_0_00_00_0_00_01_0, // idle, owner 0 (R2)
        13'b1_0_10_01_0_01_01_0, // waiter asks, owner busy, owner starts (R5 R6)
        13'b1_0_10_01_0_00_00_0, // allowance spent (R6)
        13'b1_0_10_00_0_00_00_1, // drained, swap (R3)
        13'b1_0_11_10_1_00_10_0, // busy but pipelinable, swap (R4)
        13'b1_0_11_00_0_00_01_1, // both request: alternate (R7)
        13'b1_0_11_00_0_00_10_0, // alternate again (R7)
        13'b1_0_10_01_0_00_01_0, // waiting on busy owner (R5)
        13'b1_0_00_01_0_00_01_0, // request dropped (R8)
        13'b1_0_10_01_0_01_01_0, // new request, owner spends allowance (R6)
        13'b1_0_00_01_0_00_01_0, // withdrawn in spent state (R8)
        13'b1_0_10_01_0_00_01_0  // allowance restored (R8)
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic prim, input logic pres);
        @(negedge clk);
        rst_n = 1'b0; prim_sel_i = prim; peer_present_i = pres;
        req_i = '0; pend_i = '0; pipe_rdy_i = 1'b0; ads_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        // R1: reset with master 0 as primary
        do_reset(1'b0, 1'b1);
        #1;
        check("R1 owner", 32'(owner_o), 32'd0);
        check("R1 gnt", 32'(gnt_o), 32'b01);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {peer_present_i, prim_sel_i, req_i, pend_i, pipe_rdy_i, ads_i} = VEC[v][12:3];
            #1;
            check($sformatf("vec%0d R6 ads_ok", v), 32'(ads_ok_o), 32'(VEC[v][2:1]));
            @(posedge clk);
            #1;
            check($sformatf("vec%0d R3/R4/R5/R7 owner", v), 32'(owner_o), 32'(VEC[v][0]));
            check($sformatf("vec%0d R2 gnt", v), 32'(gnt_o), 32'(2'b01 << VEC[v][0]));
        end

        // R1: reset with master 1 as primary
        do_reset(1'b1, 1'b1);
        #1;
        check("R1 owner prim1", 32'(owner_o), 32'd1);
        check("R1 gnt prim1", 32'(gnt_o), 32'b10);
        check("R2 waiter ads_ok", 32'(ads_ok_o), 32'b10);

        // R9: peer absent, secondary requests with owner idle: ignored
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        req_i = 2'b11; pend_i = 2'b00;
        repeat (3) @(negedge clk);
        check("R9 owner stays primary", 32'(owner_o), 32'd0);
        check("R9 gnt primary", 32'(gnt_o), 32'b01);
        check("R9 ads_ok primary", 32'(ads_ok_o), 32'b01);

        // R9: peer vanishes while secondary owns
        peer_present_i = 1'b1; req_i = 2'b10;
        @(negedge clk);
        check("R3 swap to secondary", 32'(owner_o), 32'd1);
        req_i = 2'b00; peer_present_i = 1'b0;
        @(negedge clk);
        check("R9 back to primary", 32'(owner_o), 32'd0);
        check("R9 gnt primary after drop", 32'(gnt_o), 32'b01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule